// File: doc/BRIEF.md
# Multi-Waveform Voice Oscillator with Sync

This block is a single tone-generator voice for a retro three-voice sound synthesizer. A 24-bit phase accumulator advances by a 16-bit frequency word on every cycle in which the 1 MHz clock-enable input is high. The enable is derived from a faster system clock outside the block. The voice shapes the accumulator into sawtooth, triangle, variable-width pulse and pseudo-random noise waveforms. A four-bit select field picks one of them, or several, which are then combined by bitwise AND. The result is a 12-bit unsigned sample.

Voices are chained. Each voice exports its accumulator MSB and a flag that marks an enable in which that MSB rises. A downstream voice takes these two signals as its source. With sync on, the source flag restarts the downstream accumulator at zero. With ring modulation on, the source MSB flips the downstream triangle fold. The rising flag is computed from the free-running sum, before any sync is applied. For that reason, a ring of three voices never forms a combinational loop.

The waveform output is combinational from registered state. A new sample therefore appears in the clock cycle that follows the enabled edge.

Top module: `wave_voice`

## Requirements
- R1: Reset clears the accumulator to zero. On each rising clock edge with `tick` high, the accumulator becomes (accumulator + `freq`) modulo 2^24.
- R2: On edges with `tick` low, the accumulator and the noise register keep their values.
- R3: Select bit 1 is the sawtooth. It equals accumulator bits 23..12.
- R4: Select bit 0 is the triangle. It equals accumulator bits 22..11, and every bit is inverted when the fold bit is 1. With ring modulation off, the fold bit is accumulator bit 23.
- R5: With `ring_en` high, the triangle fold bit is accumulator bit 23 XOR `src_msb`.
- R6: Select bit 2 is the pulse. It is 0xFFF when accumulator bits 23..12 are greater than or equal to `pulse_width`, and 0x000 otherwise.
- R7: Select bit 3 is the noise. A 23-bit shift register resets to 0x7FFFF8. It shifts left by one, taking in bit22 XOR bit17, on each enabled edge where accumulator bit 19 goes from 0 to 1. Output bits 11..4 are register bits 22, 18, 15, 12, 9, 6, 3 and 0, in that order, and output bits 3..0 are zero.
- R8: When several select bits are set, the output is the bitwise AND of the chosen waveforms. A select of zero gives 0x000.
- R9: When `tick`, `sync_en` and `src_msb_rising` are all high, the accumulator is cleared instead of advancing. When `sync_en` is low, `src_msb_rising` has no effect.
- R10: `acc_msb` is accumulator bit 23. `msb_rising` is high exactly when `tick` is high, accumulator bit 23 is 0, and bit 23 of (accumulator + `freq`) is 1. Sync does not affect this flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 MHz step enable |
| freq | input | 16 | Frequency word added per step |
| pulse_width | input | 12 | Pulse threshold |
| wave_sel | input | 4 | Waveform select: bit0 triangle, bit1 saw, bit2 pulse, bit3 noise |
| sync_en | input | 1 | Enable hard sync from the source voice |
| ring_en | input | 1 | Enable ring modulation from the source voice |
| src_msb | input | 1 | Source voice accumulator MSB |
| src_msb_rising | input | 1 | Source voice MSB rises on this step |
| wave | output | 12 | Waveform sample |
| acc_msb | output | 1 | This voice's accumulator MSB |
| msb_rising | output | 1 | This voice's MSB rises on this step |

## Verification
Accumulator, noise-register and sync effects land on the enabled clock edge. They show on `wave` one cycle after `tick` is raised, so the bench raises `tick` at a falling edge and lowers it at the next falling edge, where it then samples. `msb_rising` is combinational in the cycle in which `tick` is high, so it is sampled a little after `tick` is raised and before the edge. Select, pulse-width and ring changes act without delay, and the bench applies them while `tick` is low and samples later in the same cycle.

// File: rtl/wave_voice_pkg.sv
package wave_voice_pkg;

   // Positions of the select bits inside wave_sel
   typedef enum int unsigned {
      SEL_TRI   = 0,
      SEL_SAW   = 1,
      SEL_PULSE = 2,
      SEL_NOISE = 3
   } wsel_bit_e;

   localparam int SEL_W     = 4;
   localparam int NOISE_TAP = 8;

   // Register bit feeding noise output bit (OUT_W-NOISE_TAP+i), spread evenly over the register
   function automatic int noise_pos(input int i, input int lfsr_w);
      return (i * (lfsr_w - 1)) / (NOISE_TAP - 1);
   endfunction

endpackage

// File: rtl/wv_phase_acc.sv
module wv_phase_acc #(
   parameter int ACC_W  = 24,
   parameter int FREQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [FREQ_W-1:0] freq,
   input  logic             sync_en,
   input  logic             src_rise,
   output logic [ACC_W-1:0] acc_q,
   output logic [ACC_W-1:0] acc_nxt,
   output logic             msb_rise
);
   localparam int MSB = ACC_W - 1;

   if (FREQ_W > ACC_W) begin : g_bad_w
      $error("wv_phase_acc: FREQ_W must not exceed ACC_W");
   end

   logic [ACC_W-1:0] sum;

   always_comb begin
      sum      = acc_q + ACC_W'(freq);
      msb_rise = tick & ~acc_q[MSB] & sum[MSB];
      if (!tick)
         acc_nxt = acc_q;
      else if (sync_en && src_rise)
         acc_nxt = '0;
      else
         acc_nxt = sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_nxt;
   end
endmodule

// File: rtl/wv_noise_lfsr.sv
module wv_noise_lfsr
   import wave_voice_pkg::*;
#(
   parameter int               LFSR_W = 23,
   parameter int               TAP_A  = 22,
   parameter int               TAP_B  = 17,
   parameter logic [LFSR_W-1:0] SEED  = 23'h7FFFF8,
   parameter int               OUT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [LFSR_W-1:0] lfsr_q,
   output logic [OUT_W-1:0]  noise
);
   if (TAP_A >= LFSR_W || TAP_B >= LFSR_W) begin : g_bad_tap
      $error("wv_noise_lfsr: taps must lie inside the register");
   end
   if (OUT_W < NOISE_TAP) begin : g_bad_out
      $error("wv_noise_lfsr: OUT_W too narrow for noise taps");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("wv_noise_lfsr: seed must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         lfsr_q <= SEED;
      else if (step)
         lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[TAP_A] ^ lfsr_q[TAP_B]};
   end

   for (genvar gi = 0; gi < NOISE_TAP; gi++) begin : g_tap
      assign noise[OUT_W-NOISE_TAP+gi] = lfsr_q[noise_pos(gi, LFSR_W)];
   end
   if (OUT_W > NOISE_TAP) begin : g_pad
      assign noise[OUT_W-NOISE_TAP-1:0] = '0;
   end
endmodule

// File: rtl/wv_shaper.sv
module wv_shaper
   import wave_voice_pkg::*;
#(
   parameter int OUT_W = 12
) (
   input  logic             msb,
   input  logic [OUT_W-1:0] saw_bits,
   input  logic [OUT_W-1:0] tri_bits,
   input  logic [OUT_W-1:0] pw,
   input  logic [SEL_W-1:0] sel,
   input  logic             ring_en,
   input  logic             src_msb,
   input  logic [OUT_W-1:0] noise,
   output logic [OUT_W-1:0] wave
);
   logic             fold;
   logic [OUT_W-1:0] shapes [SEL_W];

   always_comb begin
      fold              = ring_en ? (msb ^ src_msb) : msb;
      shapes[SEL_TRI]   = fold ? ~tri_bits : tri_bits;
      shapes[SEL_SAW]   = saw_bits;
      shapes[SEL_PULSE] = (saw_bits >= pw) ? '1 : '0;
      shapes[SEL_NOISE] = noise;
      wave = (sel == '0) ? '0 : '1;
      for (int i = 0; i < SEL_W; i++) begin
         if (sel[i]) wave = wave & shapes[i];
      end
   end
endmodule

// File: rtl/wave_voice.sv
module wave_voice
   import wave_voice_pkg::*;
#(
   parameter int               ACC_W    = 24,
   parameter int               FREQ_W   = 16,
   parameter int               OUT_W    = 12,
   parameter int               LFSR_W   = 23,
   parameter int               TAP_A    = 22,
   parameter int               TAP_B    = 17,
   parameter logic [LFSR_W-1:0] SEED    = 23'h7FFFF8,
   parameter int               NOISE_BIT = 19,
   parameter bit               NOISE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [FREQ_W-1:0] freq,
   input  logic [OUT_W-1:0] pulse_width,
   input  logic [SEL_W-1:0] wave_sel,
   input  logic             sync_en,
   input  logic             ring_en,
   input  logic             src_msb,
   input  logic             src_msb_rising,
   output logic [OUT_W-1:0] wave,
   output logic             acc_msb,
   output logic             msb_rising
);
   localparam int MSB     = ACC_W - 1;
   localparam int LOW_TOP = ACC_W - OUT_W - 2;

   if (OUT_W + 2 > ACC_W) begin : g_bad_out
      $error("wave_voice: ACC_W must exceed OUT_W by at least two");
   end
   if (NOISE_BIT >= ACC_W) begin : g_bad_nbit
      $error("wave_voice: NOISE_BIT outside accumulator");
   end

   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_nxt;
   logic [LFSR_W-1:0] lfsr_q;
   logic [OUT_W-1:0]  noise;
   logic              noise_step;

   wv_phase_acc #(.ACC_W(ACC_W), .FREQ_W(FREQ_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .freq     (freq),
      .sync_en  (sync_en),
      .src_rise (src_msb_rising),
      .acc_q    (acc_q),
      .acc_nxt  (acc_nxt),
      .msb_rise (msb_rising)
   );

   assign noise_step = ~acc_q[NOISE_BIT] & acc_nxt[NOISE_BIT];

   if (NOISE_EN) begin : g_noise
      wv_noise_lfsr #(
         .LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED(SEED), .OUT_W(OUT_W)
      ) u_noise (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (noise_step),
         .lfsr_q (lfsr_q),
         .noise  (noise)
      );
   end else begin : g_no_noise
      assign lfsr_q = SEED;
      assign noise  = '0;
   end

   wv_shaper #(.OUT_W(OUT_W)) u_shape (
      .msb      (acc_q[MSB]),
      .saw_bits (acc_q[MSB -: OUT_W]),
      .tri_bits (acc_q[MSB-1 -: OUT_W]),
      .pw       (pulse_width),
      .sel      (wave_sel),
      .ring_en  (ring_en),
      .src_msb  (src_msb),
      .noise    (noise),
      .wave     (wave)
   );

   assign acc_msb = acc_q[MSB];

   logic unused_bits;
   assign unused_bits = ^{acc_q[LOW_TOP:0], acc_nxt, lfsr_q};
endmodule

// File: rtl/wave_voice_chk.sv
module wave_voice_chk #(
   parameter int ACC_W  = 24,
   parameter int FREQ_W = 16,
   parameter int OUT_W  = 12,
   parameter int LFSR_W = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [FREQ_W-1:0] freq,
   input logic [OUT_W-1:0]  pulse_width,
   input logic [3:0]        wave_sel,
   input logic              sync_en,
   input logic              src_msb_rising,
   input logic [OUT_W-1:0]  wave,
   input logic              acc_msb,
   input logic              msb_rising,
   input logic [ACC_W-1:0]  acc_q,
   input logic [LFSR_W-1:0] lfsr_q
);
   assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !(sync_en && src_msb_rising) |=> acc_q == $past(acc_q) + ACC_W'($past(freq)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(acc_q) && $stable(lfsr_q));

   assert_pulse_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wave_sel == 4'b0100 |-> wave == ((acc_q[ACC_W-1 -: OUT_W] >= pulse_width) ? {OUT_W{1'b1}} : {OUT_W{1'b0}}));

   assert_lfsr_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   assert_zero_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wave_sel == 4'b0000 |-> wave == '0);

   assert_sync_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tick && sync_en && src_msb_rising |=> acc_q == '0);

   assert_msb_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      msb_rising && !sync_en |=> acc_msb && !$past(acc_msb));
endmodule

bind wave_voice wave_voice_chk #(
   .ACC_W(ACC_W), .FREQ_W(FREQ_W), .OUT_W(OUT_W), .LFSR_W(LFSR_W)
) u_wave_voice_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .tick           (tick),
   .freq           (freq),
   .pulse_width    (pulse_width),
   .wave_sel       (wave_sel),
   .sync_en        (sync_en),
   .src_msb_rising (src_msb_rising),
   .wave           (wave),
   .acc_msb        (acc_msb),
   .msb_rising     (msb_rising),
   .acc_q          (acc_q),
   .lfsr_q         (lfsr_q)
);

// File: tb/test_wave_voice.sv
`timescale 1ns/1ps
module test_wave_voice;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] freq = '0;
   logic [11:0] pulse_width = '0;
   logic [3:0]  wave_sel = '0;
   logic        sync_en = 1'b0;
   logic        ring_en = 1'b0;
   logic        src_msb = 1'b0;
   logic        src_msb_rising = 1'b0;
   logic [11:0] wave;
   logic        acc_msb;
   logic        msb_rising;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of accumulator and noise register
   logic [23:0] m_acc;
   logic [22:0] m_lfsr;

   always #10 clk = ~clk;

   wave_voice i_wave_voice (
      .clk(clk), .rst_n(rst_n), .tick(tick), .freq(freq), .pulse_width(pulse_width),
      .wave_sel(wave_sel), .sync_en(sync_en), .ring_en(ring_en), .src_msb(src_msb),
      .src_msb_rising(src_msb_rising), .wave(wave), .acc_msb(acc_msb), .msb_rising(msb_rising)
   );

   typedef struct packed {
      logic [15:0] f;
      logic [11:0] pw;
      logic [3:0]  sel;
      logic [15:0] n;
      logic [11:0] exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{16'h1000, 12'h000, 4'h2, 16'd16,  12'h010},  // R1 R3 small saw
      '{16'hFFFF, 12'h000, 4'h2, 16'd256, 12'hFFF},  // R1 R3 near top
      '{16'h8000, 12'h000, 4'h2, 16'd512, 12'h000},  // R1 wrap to zero
      '{16'h8000, 12'h000, 4'h1, 16'd128, 12'h800},  // R4 rising half
      '{16'h8000, 12'h000, 4'h1, 16'd384, 12'h7FF},  // R4 folded
      '{16'h8000, 12'h800, 4'h4, 16'd256, 12'hFFF},  // R6 equal width
      '{16'h8000, 12'h801, 4'h4, 16'd256, 12'h000},  // R6 just above
      '{16'h8000, 12'h000, 4'h3, 16'd384, 12'h400},  // R8 saw AND tri
      '{16'h8000, 12'h000, 4'h0, 16'd384, 12'h000}   // R8 none selected
   };

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_acc = '0;
      m_lfsr = 23'h7FFFF8;
   endtask

   function automatic logic [11:0] m_noise();
      logic [11:0] r;
      r = '0;
      r[11] = m_lfsr[22]; r[10] = m_lfsr[18]; r[9] = m_lfsr[15]; r[8] = m_lfsr[12];
      r[7]  = m_lfsr[9];  r[6]  = m_lfsr[6];  r[5] = m_lfsr[3];  r[4] = m_lfsr[0];
      return r;
   endfunction

   // one enabled edge per call; model follows unless sync clears
   task automatic steps(input int n);
      for (int k = 0; k < n; k++) begin
         logic [23:0] nx;
         @(negedge clk);
         tick = 1'b1;
         nx = (sync_en && src_msb_rising) ? 24'h0 : m_acc + {8'h0, freq};
         if (!m_acc[19] && nx[19]) m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
         m_acc = nx;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state (R1, R7, R10)
      do_reset();
      wave_sel = 4'h2;
      #2;
      check("R1 saw after reset", {12'h0, wave}, 24'h0);
      check("R10 acc_msb after reset", {23'h0, acc_msb}, 24'h0);
      check("R10 msb_rising idle", {23'h0, msb_rising}, 24'h0);
      wave_sel = 4'h8;
      #2;
      check("R7 noise seed", {12'h0, wave}, 24'hFE0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         do_reset();
         freq = VECS[v].f;
         pulse_width = VECS[v].pw;
         wave_sel = VECS[v].sel;
         steps(int'(VECS[v].n));
         #2;
         check($sformatf("R1/R3/R4/R6/R8 row %0d", v), {12'h0, wave}, {12'h0, VECS[v].exp});
      end

      // R2: no tick, no change
      do_reset();
      freq = 16'h1234; wave_sel = 4'h2;
      steps(10);
      repeat (20) @(negedge clk);
      #2;
      check("R2 hold without tick", {12'h0, wave}, {12'h0, m_acc[23:12]});

      // R5 ring modulation
      do_reset();
      freq = 16'h8000; wave_sel = 4'h1;
      steps(128);                       // accumulator 0x400000
      ring_en = 1'b1; src_msb = 1'b1;
      #2;
      check("R5 ring fold by source", {12'h0, wave}, 24'h7FF);
      src_msb = 1'b0;
      #2;
      check("R5 ring source low", {12'h0, wave}, 24'h800);
      ring_en = 1'b0; src_msb = 1'b1;
      #2;
      check("R5 ring off ignores source", {12'h0, wave}, 24'h800);
      src_msb = 1'b0;

      // R9 hard sync
      do_reset();
      freq = 16'h1000; wave_sel = 4'h2;
      steps(100);
      sync_en = 1'b1; src_msb_rising = 1'b1;
      steps(1);
      #2;
      check("R9 sync clears", {12'h0, wave}, 24'h000);
      sync_en = 1'b0;
      steps(1);
      #2;
      check("R9 sync off ignores source", {12'h0, wave}, 24'h001);
      src_msb_rising = 1'b0;

      // R10 msb rising flag
      do_reset();
      freq = 16'h8000;
      steps(255);                       // accumulator 0x7F8000
      @(negedge clk);
      tick = 1'b1;
      #2;
      check("R10 rising flag before edge", {23'h0, msb_rising}, 24'h1);
      check("R10 msb before edge", {23'h0, acc_msb}, 24'h0);
      @(negedge clk);
      tick = 1'b0;
      #2;
      check("R10 msb after edge", {23'h0, acc_msb}, 24'h1);
      check("R10 flag clears", {23'h0, msb_rising}, 24'h0);

      // R7 noise stepping
      do_reset();
      freq = 16'hFFFF; wave_sel = 4'h8;
      for (int r = 0; r < 6; r++) begin
         steps(40);
         #2;
         check($sformatf("R7 noise round %0d", r), {12'h0, wave}, {12'h0, m_noise()});
      end

      // R8 pulse AND noise
      wave_sel = 4'hC; pulse_width = 12'h000;
      #2;
      check("R8 pulse AND noise", {12'h0, wave}, {12'h0, m_noise()});

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule